// File: doc/BRIEF.md
# Sampling Converter Serial Control Sequencer

This block is the digital control side of a sampling analog-to-digital converter, seen from its three- or four-wire serial port. A host drives chip select, an optional frame-sync strobe and the serial clock. The block counts serial-clock edges in each frame. It opens a sampling window, starts a conversion in an external abstract conversion engine, and collects that engine's 14-bit result through a done strobe. The result of each frame is shifted out during the next frame, most significant bit first.

Chip select, frame sync and the serial clock are brought into one system clock domain, and all edge detection happens there. A frame that is too short to be a normal frame acts as the initialisation frame. A fixed marker word, 3FC0h, replaces the result in the frame after an initialisation, and also in any frame that cut a running conversion short. Between conversions the block reports itself powered down, and it wakes at the start of the next frame.

Top module: `adc_serial_seq`

## Requirements
- R1: After a synchronous reset, sdo_oe, sample_en and convert_en are low and power_down is high.
- R2: Before the first initialisation frame, no frame raises sample_en or convert_en, and every frame shifts out the marker 3FC0h.
- R3: A frame that ends after 1 to 8 serial-clock falling edges is an initialisation frame. A frame ends on a chip-select rise or, with chip select low, on a frame-sync rise. The next frame shifts out 3FC0h. A frame ending after 9 or more falling edges is not an initialisation frame and leaves the held result unchanged.
- R4: In an initialised frame, sample_en is high after falling edges 4 through 23 of the frame and low after the earlier ones. That makes a window of 20 clock periods, starting in the 5th.
- R5: convert_en rises after the 24th falling edge. It stays high through a chip-select rise until the engine's done strobe. The result captured at that strobe is shifted out by the next frame.
- R6: The output word is 16 bits. Bits 15:2 hold the 14-bit straight-binary result and bits 1:0 are zero. After the k-th serial-clock rising edge of a frame (k = 1..16), sdo carries bit 16-k.
- R7: At frame presentation, before any serial-clock edge, sdo_oe goes high with bit 15 on sdo. Presentation is a chip-select fall while frame sync is high, or a frame-sync rise while chip select is low.
- R8: sdo_oe is low while chip select is high, from the 17th serial-clock rising edge of a frame, and from a chip-select rise.
- R9: In frame-sync mode (chip select held low), the frame-sync fall starts the edge count. A chip-select fall while frame sync is low presents nothing.
- R10: If a frame is presented while convert_en is high and no done strobe has arrived, the conversion is dropped, convert_en falls, and that frame shifts out 3FC0h.
- R11: power_down rises when a conversion completes and falls at the next frame presentation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| fs | input | 1 | Frame sync strobe, asynchronous; held high when unused |
| sclk | input | 1 | Host serial clock, asynchronous |
| conv_done | input | 1 | One-cycle completion strobe from the conversion engine |
| conv_result | input | RES_W | Conversion result, valid with conv_done |
| sdo | output | 1 | Serial data bit, meaningful only while sdo_oe is high |
| sdo_oe | output | 1 | Output enable of the serial data pad (low = high impedance) |
| sample_en | output | 1 | Sampling window active |
| convert_en | output | 1 | Conversion requested and running |
| power_down | output | 1 | Idle between conversions |

## Verification
The bench sweeps the length of the initialisation frame across every value from 1 to 8 falling edges, and then uses a 9-edge frame. A design with an off-by-one limit would either miss a valid initialisation or wipe a good result. Each frame pits the bit read after every rising edge against a word computed from the previous frame's code; a design that shifts on the first rise would lose the MSB and a design without the pipeline would show the current code. The bench starts a frame while a conversion is still running, where a design that completes the conversion would show a stale code instead of 3FC0h. It also drives frame-sync-only frames, including an initialisation frame ended by a frame-sync rise, where a design that reads the held word before applying that initialisation would present the old result.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  // Synchronised view of one asynchronous control pin.
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } pin_ev_t;

  localparam int PIN_CS   = 0;
  localparam int PIN_FS   = 1;
  localparam int PIN_SCLK = 2;
  localparam int NUM_PINS = 3;
endpackage

// File: rtl/adc_seq_edge_sync.sv
`timescale 1ns/1ps
module adc_seq_edge_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  // stg[0..STAGES-1] resynchronise, stg[STAGES] holds the previous level.
  logic [W-1:0] stg [0:STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~stg[STAGES];
  assign fall = ~stg[STAGES-1] & stg[STAGES];
endmodule

// File: rtl/adc_seq_frame_ctl.sv
`timescale 1ns/1ps
module adc_seq_frame_ctl import adc_seq_pkg::*; #(
  parameter int RES_W = 14,
  parameter int WORD_W = 16,
  parameter int SAMPLE_FALL = 4,
  parameter int CONV_FALL = 24,
  parameter int RESET_MAX = 8,
  parameter logic [WORD_W-1:0] MARKER = 'h3FC0
) (
  input  logic              clk,
  input  logic              rst,
  input  pin_ev_t           cs_ev,
  input  pin_ev_t           fs_ev,
  input  logic              sclk_fall,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              present,
  output logic              load,
  output logic [WORD_W-1:0] word,
  output logic              active,
  output logic              sample_en,
  output logic              convert_en,
  output logic              power_down
);
  localparam int PAD_W = WORD_W - RES_W;
  localparam int CNT_W = $clog2(CONV_FALL + 1);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
  localparam logic [CNT_W-1:0] SAMP_C = CNT_W'(SAMPLE_FALL);
  localparam logic [CNT_W-1:0] CONV_C = CNT_W'(CONV_FALL);
  localparam logic [CNT_W-1:0] RMAX_C = CNT_W'(RESET_MAX);

  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic              init_q;
  logic [WORD_W-1:0] held;
  logic [WORD_W-1:0] captured, next_word;
  logic              start, end_ev, reset_end, done_now;

  // Presentation drives the MSB; start begins the falling-edge count.
  assign present   = (cs_ev.fall && fs_ev.lvl) || (fs_ev.rise && !cs_ev.lvl);
  assign start     = (cs_ev.fall && fs_ev.lvl) || (fs_ev.fall && !cs_ev.lvl);
  assign end_ev    = active && (cs_ev.rise || (fs_ev.rise && !cs_ev.lvl));
  assign reset_end = end_ev && (cnt >= ONE_C) && (cnt <= RMAX_C);
  assign done_now  = conv_done && convert_en;
  assign captured  = {conv_result, {PAD_W{1'b0}}};
  assign cnt_nx    = cnt + ONE_C;

  always_comb begin
    if (reset_end)       next_word = MARKER;
    else if (done_now)   next_word = captured;
    else if (convert_en) next_word = MARKER;  // cut short by this frame
    else                 next_word = held;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      active     <= 1'b0;
      init_q     <= 1'b0;
      held       <= MARKER;
      word       <= MARKER;
      load       <= 1'b0;
      sample_en  <= 1'b0;
      convert_en <= 1'b0;
      power_down <= 1'b1;
    end else begin
      load <= present;
      if (present) word <= next_word;

      if (done_now) begin
        held       <= captured;
        convert_en <= 1'b0;
        power_down <= 1'b1;
      end

      if (end_ev) begin
        active    <= 1'b0;
        sample_en <= 1'b0;
        cnt       <= '0;
        if (reset_end) begin
          init_q <= 1'b1;
          held   <= MARKER;
        end
        if (cnt < CONV_C) power_down <= 1'b1;
      end else if (active && sclk_fall && (cnt < CONV_C)) begin
        cnt <= cnt_nx;
        if (init_q && (cnt_nx == SAMP_C)) sample_en <= 1'b1;
        if (init_q && (cnt_nx == CONV_C)) begin
          sample_en  <= 1'b0;
          convert_en <= 1'b1;
        end
      end

      if (start) begin
        active    <= 1'b1;
        cnt       <= '0;
        sample_en <= 1'b0;
      end

      if (present) begin
        power_down <= 1'b0;
        if (convert_en && !conv_done) begin
          convert_en <= 1'b0;
          held       <= MARKER;
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_shifter.sv
`timescale 1ns/1ps
module adc_seq_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              shift_tick,
  input  logic              hiz,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int RC_W = $clog2(WORD_W + 2);
  localparam logic [RC_W-1:0] LAST_C = RC_W'(WORD_W + 1);

  logic [WORD_W-1:0] sh;
  logic [RC_W-1:0]   rc, rc_nx;

  assign rc_nx = rc + RC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      rc     <= '0;
      sdo_oe <= 1'b0;
    end else if (load) begin
      sh     <= word;
      rc     <= '0;
      sdo_oe <= 1'b1;
    end else if (hiz) begin
      sdo_oe <= 1'b0;
    end else if (shift_tick && sdo_oe) begin
      rc <= rc_nx;
      // The first rising edge keeps the MSB on the line.
      if (rc != '0) sh <= {sh[WORD_W-2:0], 1'b0};
      if (rc_nx == LAST_C) sdo_oe <= 1'b0;
    end
  end

  assign sdo = sh[WORD_W-1] & sdo_oe;
endmodule

// File: rtl/adc_serial_seq.sv
`timescale 1ns/1ps
module adc_serial_seq import adc_seq_pkg::*; #(
  parameter int RES_W = 14,
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_FALL = 4,
  parameter int CONV_FALL = 24,
  parameter int RESET_MAX = 8,
  parameter logic [WORD_W-1:0] MARKER = 'h3FC0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             fs,
  input  logic             sclk,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             sample_en,
  output logic             convert_en,
  output logic             power_down
);
  localparam logic [NUM_PINS-1:0] PIN_RST =
    NUM_PINS'((1 << PIN_CS) | (1 << PIN_FS));

  logic [NUM_PINS-1:0] raw, lvl, rise, fall;
  pin_ev_t             ev [NUM_PINS];

  assign raw[PIN_CS]   = cs_n;
  assign raw[PIN_FS]   = fs;
  assign raw[PIN_SCLK] = sclk;

  adc_seq_edge_sync #(
    .W(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)
  ) sync_i (
    .clk(clk), .rst(rst), .din(raw), .lvl(lvl), .rise(rise), .fall(fall)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ev
    assign ev[g] = '{lvl: lvl[g], rise: rise[g], fall: fall[g]};
  end

  logic              cs_lvl, cs_rise, sclk_rise, sclk_fall;
  logic              present, load, active;
  logic [WORD_W-1:0] word;

  assign cs_lvl    = ev[PIN_CS].lvl;
  assign cs_rise   = ev[PIN_CS].rise;
  assign sclk_rise = ev[PIN_SCLK].rise;
  assign sclk_fall = ev[PIN_SCLK].fall;

  adc_seq_frame_ctl #(
    .RES_W(RES_W), .WORD_W(WORD_W), .SAMPLE_FALL(SAMPLE_FALL),
    .CONV_FALL(CONV_FALL), .RESET_MAX(RESET_MAX), .MARKER(MARKER)
  ) ctl_i (
    .clk(clk), .rst(rst), .cs_ev(ev[PIN_CS]), .fs_ev(ev[PIN_FS]),
    .sclk_fall(sclk_fall), .conv_done(conv_done), .conv_result(conv_result),
    .present(present), .load(load), .word(word), .active(active),
    .sample_en(sample_en), .convert_en(convert_en), .power_down(power_down)
  );

  adc_seq_shifter #(.WORD_W(WORD_W)) shf_i (
    .clk(clk), .rst(rst), .load(load), .word(word),
    .shift_tick(active && sclk_rise), .hiz(cs_rise),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: rtl/adc_seq_checker.sv
`timescale 1ns/1ps
module adc_seq_checker (
  input logic clk,
  input logic rst,
  input logic cs_lvl,
  input logic cs_rise,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic present,
  input logic load,
  input logic conv_done,
  input logic sample_en,
  input logic convert_en,
  input logic power_down,
  input logic sdo_oe
);
  assert_hiz_cs_high_R8: assert property (@(posedge clk) disable iff (rst)
    (cs_lvl && $past(cs_lvl)) |-> !sdo_oe);

  assert_oe_drop_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(sdo_oe) |-> ($past(cs_rise) || $past(sclk_rise)));

  assert_msb_driven_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> sdo_oe);

  assert_window_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_en) |-> $past(sclk_fall));

  assert_sample_convert_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(sample_en && convert_en));

  assert_convert_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (convert_en && !conv_done && !present) |=> convert_en);

  assert_convert_after_window_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(convert_en) |-> ($past(sclk_fall) && $past(sample_en)));

  assert_sleep_on_done_R11: assert property (@(posedge clk) disable iff (rst)
    (conv_done && convert_en && !present) |=> power_down);

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (present && convert_en && !conv_done) |=> !convert_en);
endmodule

bind adc_serial_seq adc_seq_checker chk_i (
  .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .present(present),
  .load(load), .conv_done(conv_done), .sample_en(sample_en),
  .convert_en(convert_en), .power_down(power_down), .sdo_oe(sdo_oe)
);

// File: tb/adc_serial_seq_tb_top.sv
`timescale 1ns/1ps
module adc_serial_seq_tb_top;
  localparam int H = 6;          // system clocks per serial half period
  localparam int CONV_CYC = 40;  // engine latency in system clocks
  localparam int GAP = 80;
  localparam logic [15:0] MARKER = 16'h3FC0;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, fs = 1'b1, sclk = 1'b0, conv_done = 1'b0;
  logic [13:0] conv_result = '0;
  logic sdo, sdo_oe, sample_en, convert_en, power_down;

  always #5 clk = ~clk;

  adc_serial_seq dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fs(fs), .sclk(sclk),
    .conv_done(conv_done), .conv_result(conv_result), .sdo(sdo),
    .sdo_oe(sdo_oe), .sample_en(sample_en), .convert_en(convert_en),
    .power_down(power_down)
  );

  // Abstract conversion engine
  logic [13:0] eng_code = '0;
  int  ecnt = 0;
  bit  ebusy = 0;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (!convert_en) begin
      ebusy <= 0; ecnt <= 0;
    end else if (!ebusy) begin
      ebusy <= 1; ecnt <= 1;
    end else if (ecnt == CONV_CYC) begin
      conv_done <= 1'b1; conv_result <= eng_code; ecnt <= ecnt + 1;
    end else if (ecnt < CONV_CYC) begin
      ecnt <= ecnt + 1;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] wd(input logic [13:0] c);
    return {c, 2'b00};
  endfunction

  // win: 0 = no window allowed, 1 = window expected, 2 = unchecked
  task automatic frame_body(input int nf, input logic [15:0] exp, input bit cw,
                            input int win, input string tag);
    logic [15:0] got = '0;
    bit oe_all = 1;
    for (int k = 1; k <= nf; k++) begin
      sclk = 1'b1; tick(H);
      if (k <= 16) begin got[16-k] = sdo; oe_all &= sdo_oe; end
      if (k == 17) chk(!sdo_oe, "R8 hi-Z after 17th rise", sdo_oe, 0);
      sclk = 1'b0; tick(H);
      if (win == 1) begin
        chk(sample_en == (k >= 4 && k < 24), "R4 sampling window", sample_en, (k >= 4 && k < 24));
        if (k == 24) chk(convert_en, "R5 convert after 24th fall", convert_en, 1);
      end else if (win == 0) begin
        chk(!sample_en && !convert_en, "R2 no sampling before init", {sample_en, convert_en}, 0);
      end
    end
    if (cw && nf >= 16) chk(oe_all && got == exp, tag, got, exp);
  endtask

  task automatic frame_cs(input int nf, input logic [15:0] exp, input bit cw,
                          input int win, input string tag);
    cs_n = 1'b0; tick(H);
    chk(!power_down, "R11 wake on cs fall", power_down, 0);
    if (cw) chk(sdo_oe && sdo == exp[15], "R7 MSB at cs fall", {sdo_oe, sdo}, {1'b1, exp[15]});
    frame_body(nf, exp, cw, win, tag);
    cs_n = 1'b1; tick(H);
    chk(!sdo_oe, "R8 hi-Z with cs high", sdo_oe, 0);
  endtask

  task automatic frame_fs(input int nf, input logic [15:0] exp, input bit cw,
                          input int win, input string tag);
    fs = 1'b1; tick(H);
    chk(!power_down, "R11 wake on fs rise", power_down, 0);
    if (cw) chk(sdo_oe && sdo == exp[15], "R7 R9 MSB at fs rise", {sdo_oe, sdo}, {1'b1, exp[15]});
    fs = 1'b0; tick(H);
    frame_body(nf, exp, cw, win, tag);
  endtask

  initial begin
    logic [15:0] prev;
    logic [13:0] c;
    tick(5); rst = 1'b0; tick(4);
    chk(!sdo_oe, "R1 reset oe", sdo_oe, 0);
    chk(!sample_en, "R1 reset sample_en", sample_en, 0);
    chk(!convert_en, "R1 reset convert_en", convert_en, 0);
    chk(power_down, "R1 reset power_down", power_down, 1);

    // R2: uninitialised frame
    frame_cs(24, MARKER, 1, 0, "R2 marker before init");
    tick(GAP);
    chk(!convert_en, "R2 no conversion before init", convert_en, 0);

    // R3: sweep initialisation frame length 1..8
    for (int n = 1; n <= 8; n++) begin
      c = 14'((n * 2731 + 77) % 16384);
      frame_cs(n, 16'h0, 0, 2, "");
      tick(GAP);
      eng_code = c;
      frame_cs(24, MARKER, 1, 1, "R3 marker after init frame");
      tick(GAP);
      chk(power_down && !convert_en, "R11 asleep after conversion", {power_down, convert_en}, 2);
      frame_cs(24, wd(c), 1, 1, "R5 R6 result one frame later");
      tick(GAP);
    end
    prev = wd(14'((8 * 2731 + 77) % 16384));

    // R3: 9 falls is not an initialisation frame
    frame_cs(9, prev, 1, 1, "");
    tick(GAP);
    frame_cs(24, prev, 1, 1, "R3 nine falls keep held result");
    tick(GAP);

    // R6: code sweep through the one-frame pipeline
    for (int i = 0; i < 6; i++) begin
      case (i)
        0: c = 14'h0000; 1: c = 14'h3FFF; 2: c = 14'h2AAA;
        3: c = 14'h1555; 4: c = 14'h0001; default: c = 14'h2000;
      endcase
      eng_code = c;
      frame_cs(24, prev, 1, 1, "R6 word format");
      tick(GAP);
      prev = wd(c);
    end

    // R8: early chip-select rise mid-word; held word survives
    frame_cs(12, prev, 1, 1, "");
    tick(GAP);
    eng_code = 14'h1234;
    frame_cs(24, prev, 1, 1, "R8 partial read keeps word");
    tick(GAP);
    prev = wd(14'h1234);

    // R10: new frame during conversion
    eng_code = 14'h0ABC;
    frame_cs(24, prev, 1, 1, "R6 word before abort");
    tick(2);
    eng_code = 14'h0DEF;
    frame_cs(24, MARKER, 1, 1, "R10 aborted conversion gives marker");
    tick(GAP);
    frame_cs(24, wd(14'h0DEF), 1, 1, "R10 recovery after abort");
    tick(GAP);
    prev = wd(14'h0DEF);

    // R9: frame-sync mode
    fs = 1'b0; tick(H);
    cs_n = 1'b0; tick(H);
    chk(!sdo_oe, "R9 cs fall with fs low presents nothing", sdo_oe, 0);
    eng_code = 14'h3333;
    frame_fs(24, prev, 1, 1, "R9 fs-mode word");
    tick(GAP);
    chk(power_down, "R11 asleep in fs mode", power_down, 1);
    eng_code = 14'h0777;
    frame_fs(24, wd(14'h3333), 1, 1, "R9 fs-mode pipeline");
    tick(GAP);
    frame_fs(3, 16'h0, 0, 2, "");
    eng_code = 14'h2468;
    frame_fs(24, MARKER, 1, 1, "R3 init ended by fs rise");
    tick(GAP);
    frame_fs(24, wd(14'h2468), 1, 1, "R9 fs-mode after init");
    tick(GAP);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule